// File: doc/BRIEF.md
# Calibrated Trigger Sum Builder

This block turns one set of sixteen 14-bit ADC samples into a handful of 16-bit trigger sums. It accepts a new set on every sample clock. Each channel first has its own stored baseline removed. Any result below zero is clamped to zero. The clamped value is then scaled by a per-channel weight between 0.75 and just under 1.25. The weighted channels are added in groups. A single mode input picks the grouping: either four sums of four adjacent channels, or two sums of eight adjacent channels.

The raw group sums carry 18 bits of range. A selectable right shift of 0, 1 or 2 bits brings them down to 16 bits, and anything still too large is clamped to all ones. The baseline and weight tables are loaded through a simple write port while the system starts up, and are not changed afterwards.

The grouping mode and the shift selection are static configuration. They act on the last pipeline stage, so they must not change while samples are in flight.

Top module: `trig_sum_builder`

## Requirements
- R1: Synchronous active-low reset clears `out_valid` and all of `out_sums` to zero. It also sets every channel's baseline to 0 and every gain code to 128, so after reset each weighted channel equals its raw sample.
- R2: For channel c, the bits `in_samples[14c+13:14c]` minus that channel's stored baseline give the difference d. When the sample is below the baseline, d is 0.
- R3: The weighted value of a channel is floor(d * (384 + g) / 512), where g is the channel's 8-bit gain code.
- R4: With `mode_quad` = 1, sum k (`out_sums[16k+15:16k]`, k = 0..3) adds the weighted channels 4k to 4k+3.
- R5: With `mode_quad` = 0, sum 0 adds channels 0 to 7, sum 1 adds channels 8 to 15, and sums 2 and 3 are zero.
- R6: Each group sum is shifted right by `shift_sel` bits (0, 1 or 2). A value of 3 acts as 2.
- R7: A shifted sum greater than 65535 is output as 65535.
- R8: `out_valid` is high exactly 4 clocks after `in_valid` was sampled high. Samples presented on consecutive clocks give results on consecutive clocks.
- R9: When `tbl_we` is high on a clock edge, the baseline `tbl_ped` and gain code `tbl_gain` are stored for channel `tbl_addr`. A sample taken on that same edge still uses the old entry; samples from the next edge on use the new one.
- R10: While `out_valid` is low, `out_sums` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A sample set is present on `in_samples` |
| in_samples | input | 224 | Sixteen 14-bit samples, channel c at bits 14c+13:14c |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Channel index for the table write |
| tbl_ped | input | 14 | Baseline value to store |
| tbl_gain | input | 8 | Gain code to store |
| mode_quad | input | 1 | 1: four 4-channel sums, 0: two 8-channel sums |
| shift_sel | input | 2 | Right shift applied before clamping to 16 bits |
| out_valid | output | 1 | New sums are present on `out_sums` |
| out_sums | output | 64 | Four 16-bit sums, sum k at bits 16k+15:16k |

## Verification
A table write and an incoming sample can land on the same clock edge. The issue is whether the sample in flight uses the old calibration or a mix of old and new values. The bench creates this case by raising `tbl_we` for channel 0 in the same cycle as `in_valid`, and presenting a second sample on the next cycle. It then requires the first result to match a model built entirely from the old entry, and the second result to match the new one. A baseline change that is large enough makes the two results clearly distinct.

// File: rtl/tsb_pkg.sv
// Shared definitions for the trigger sum builder.
// Assumes: groups are built from blocks of four adjacent channels.
package tsb_pkg;

    // Number of channels that form one quad group.
    localparam int unsigned QUAD_CH = 4;

    // Grouping selection carried on the mode input.
    typedef enum logic {
        GRP_PAIR = 1'b0,
        GRP_QUAD = 1'b1
    } grp_mode_e;

    // Clamp a shift selector to the largest supported shift of 2.
    function automatic logic [1:0] clip_shift(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction

endpackage

// File: rtl/tsb_cal_table.sv
// Per-channel calibration storage: one baseline and one gain code per channel.
// Assumes: it is written only while the system starts up; reset loads
// baseline 0 and the unity gain code (384 + UNITY_G = 512).
module tsb_cal_table #(
    parameter int unsigned NCH = 16,
    parameter int unsigned SW  = 14,
    parameter int unsigned GW  = 8,
    localparam int unsigned AW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [SW-1:0]     ped_in,
    input  logic [GW-1:0]     gain_in,
    output logic [NCH*SW-1:0] ped_flat,
    output logic [NCH*GW-1:0] gain_flat
);

    localparam logic [GW-1:0] UNITY_G = GW'(1) << (GW - 1);

    for (genvar i = 0; i < NCH; i++) begin : g_entry
        logic [SW-1:0] ped_q;
        logic [GW-1:0] gain_q;

        // Store a new entry when this channel is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ped_q  <= '0;
                gain_q <= UNITY_G;
            end else if (we && addr == AW'(i)) begin
                ped_q  <= ped_in;
                gain_q <= gain_in;
            end
        end

        assign ped_flat[i*SW +: SW]  = ped_q;
        assign gain_flat[i*GW +: GW] = gain_q;
    end

endmodule

// File: rtl/tsb_chan_cal.sv
// One channel's calibration: subtract the baseline and clamp at zero
// (stage 1), then multiply by 0.75 + g/2^(GW+1) and keep the floor (stage 2).
// Assumes: the pipeline runs on every clock; validity is tracked by the parent.
module tsb_chan_cal #(
    parameter int unsigned SW = 14,
    parameter int unsigned GW = 8,
    localparam int unsigned WW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sample,
    input  logic [SW-1:0] ped,
    input  logic [GW-1:0] gain,
    output logic [WW-1:0] weighted
);

    localparam int unsigned MW = GW + 2;
    localparam int unsigned PW = SW + MW;
    localparam logic [MW-1:0] BASE = MW'(3) << (GW - 1);

    logic [SW-1:0] diff_q;
    logic [GW-1:0] gain_q;
    logic [PW-1:0] prod;
    logic [WW-1:0] w_q;

    // Stage 1: clamped difference, captured together with its gain code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            gain_q <= '0;
        end else begin
            diff_q <= (sample > ped) ? (sample - ped) : '0;
            gain_q <= gain;
        end
    end

    assign prod = PW'(diff_q) * PW'(BASE + MW'(gain_q));

    // Stage 2: weighted value, dropping the fractional bits.
    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= WW'(prod >> (GW + 1));
    end

    assign weighted = w_q;

endmodule

// File: rtl/tsb_group_sum.sv
// Adds weighted channels in blocks of four (stage 3). Then it forms the
// selected grouping, shifts and clamps to the output width (stage 4).
// Assumes: the mode and shift inputs are steady while samples are in flight.
module tsb_group_sum
    import tsb_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned WW  = 15,
    parameter int unsigned OW  = 16,
    localparam int unsigned NQ   = NCH / QUAD_CH,
    localparam int unsigned QW   = WW + 2,
    localparam int unsigned SUMW = WW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_in,
    input  logic [NCH*WW-1:0] w_flat,
    input  logic              mode_quad,
    input  logic [1:0]        shift_sel,
    output logic              v_out,
    output logic [NQ*OW-1:0]  sums
);

    localparam logic [SUMW-1:0] OMAX = SUMW'({OW{1'b1}});

    logic [QW-1:0]   quad_c [NQ];
    logic [QW-1:0]   quad_q [NQ];
    logic [SUMW-1:0] grp    [NQ];
    logic [OW-1:0]   sat    [NQ];
    logic            v3_q;
    logic [1:0]      sh;

    for (genvar k = 0; k < NQ; k++) begin : g_quad
        // Adder tree for one block of four channels.
        always_comb begin
            quad_c[k] = '0;
            for (int j = 0; j < int'(QUAD_CH); j++)
                quad_c[k] = quad_c[k] + QW'(w_flat[(k*QUAD_CH + j)*WW +: WW]);
        end

        // Stage 3: register the block sum.
        always_ff @(posedge clk) begin
            if (!rst_n) quad_q[k] <= '0;
            else        quad_q[k] <= quad_c[k];
        end
    end

    // Stage 3 validity.
    always_ff @(posedge clk) begin
        if (!rst_n) v3_q <= 1'b0;
        else        v3_q <= v_in;
    end

    assign sh = clip_shift(shift_sel);

    for (genvar k = 0; k < NQ; k++) begin : g_out
        // Grouping select: a block sum or the sum of two neighbouring blocks.
        always_comb begin
            if (grp_mode_e'(mode_quad) == GRP_QUAD)
                grp[k] = SUMW'(quad_q[k]);
            else if (k < NQ / 2)
                grp[k] = SUMW'(quad_q[2*k]) + SUMW'(quad_q[2*k+1]);
            else
                grp[k] = '0;
        end

        // Range reduction followed by clamping to the output width.
        always_comb begin
            logic [SUMW-1:0] shifted;
            shifted = grp[k] >> sh;
            sat[k]  = (shifted > OMAX) ? {OW{1'b1}} : shifted[OW-1:0];
        end

        // Stage 4: load the output only when a result arrives.
        always_ff @(posedge clk) begin
            if (!rst_n)    sums[k*OW +: OW] <= '0;
            else if (v3_q) sums[k*OW +: OW] <= sat[k];
        end
    end

    // Stage 4 validity.
    always_ff @(posedge clk) begin
        if (!rst_n) v_out <= 1'b0;
        else        v_out <= v3_q;
    end

endmodule

// File: rtl/trig_sum_builder.sv
// Top of the trigger sum builder: calibration table, one calibration lane
// per channel, and the grouping/reduction stage. Fixed latency of 4 clocks.
// Assumes: table writes happen during start-up; mode and shift are static.
module trig_sum_builder #(
    parameter int unsigned NCH = 16,
    parameter int unsigned SW  = 14,
    parameter int unsigned GW  = 8,
    parameter int unsigned OW  = 16,
    localparam int unsigned AW = $clog2(NCH),
    localparam int unsigned WW = SW + 1,
    localparam int unsigned NQ = NCH / tsb_pkg::QUAD_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [NCH*SW-1:0] in_samples,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [SW-1:0]     tbl_ped,
    input  logic [GW-1:0]     tbl_gain,
    input  logic              mode_quad,
    input  logic [1:0]        shift_sel,
    output logic              out_valid,
    output logic [NQ*OW-1:0]  out_sums
);

    logic [NCH*SW-1:0] ped_flat;
    logic [NCH*GW-1:0] gain_flat;
    logic [NCH*WW-1:0] w_flat;
    logic              v1_q;
    logic              v2_q;

    tsb_cal_table #(.NCH(NCH), .SW(SW), .GW(GW)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tbl_we),
        .addr      (tbl_addr),
        .ped_in    (tbl_ped),
        .gain_in   (tbl_gain),
        .ped_flat  (ped_flat),
        .gain_flat (gain_flat)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        tsb_chan_cal #(.SW(SW), .GW(GW)) u_cal (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample   (in_samples[c*SW +: SW]),
            .ped      (ped_flat[c*SW +: SW]),
            .gain     (gain_flat[c*GW +: GW]),
            .weighted (w_flat[c*WW +: WW])
        );
    end

    // Validity for the two calibration stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
        end
    end

    tsb_group_sum #(.NCH(NCH), .WW(WW), .OW(OW)) u_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .v_in      (v2_q),
        .w_flat    (w_flat),
        .mode_quad (mode_quad),
        .shift_sel (shift_sel),
        .v_out     (out_valid),
        .sums      (out_sums)
    );

endmodule

// File: rtl/tsb_chk.sv
// Timing checks on the trigger sum builder's ports. A warm-up counter keeps
// every look into the past inside the cycles since reset was released.
module tsb_chk #(
    parameter int unsigned NQ = 4,
    parameter int unsigned OW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             mode_quad,
    input logic             out_valid,
    input logic [NQ*OW-1:0] out_sums
);

    logic [2:0] warm;

    // Count clocks since reset was released, stopping at 4.
    always_ff @(posedge clk) begin
        if (!rst_n)           warm <= '0;
        else if (warm != 3'd4) warm <= warm + 3'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd0) |-> (!out_valid && out_sums == '0));

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R5
    pair_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 3'd0 && out_valid && !$past(mode_quad)) |->
            (out_sums[NQ*OW-1:(NQ/2)*OW] == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 3'd0 && !out_valid) |-> $stable(out_sums));

endmodule

bind trig_sum_builder tsb_chk #(.NQ(NQ), .OW(OW)) u_tsb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode_quad (mode_quad),
    .out_valid (out_valid),
    .out_sums  (out_sums)
);

// File: tb/trig_sum_builder_bench.sv
// Directed bench for the trigger sum builder: one task per scenario.
module trig_sum_builder_bench;

    localparam int CLK_T = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [223:0] in_samples = '0;
    logic         tbl_we = 1'b0;
    logic [3:0]   tbl_addr = '0;
    logic [13:0]  tbl_ped = '0;
    logic [7:0]   tbl_gain = '0;
    logic         mode_quad = 1'b1;
    logic [1:0]   shift_sel = 2'd0;
    logic         out_valid;
    logic [63:0]  out_sums;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int cur_s  [16];
    int ped_m  [16];
    int gain_m [16];

    always #(CLK_T/2) clk = ~clk;

    trig_sum_builder u_trig_sum_builder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_ped(tbl_ped), .tbl_gain(tbl_gain),
        .mode_quad(mode_quad), .shift_sel(shift_sel),
        .out_valid(out_valid), .out_sums(out_sums)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected sums built from the requirements and the bench's table copy.
    function automatic logic [63:0] model();
        int w [16];
        logic [63:0] r = '0;
        int sh = (shift_sel == 2'd3) ? 2 : int'(shift_sel);
        for (int c = 0; c < 16; c++) begin
            int d = cur_s[c] - ped_m[c];
            if (d < 0) d = 0;
            w[c] = (d * (384 + gain_m[c])) / 512;
        end
        for (int k = 0; k < 4; k++) begin
            int s = 0;
            if (mode_quad) for (int j = 0; j < 4; j++) s += w[4*k + j];
            else if (k < 2) for (int j = 0; j < 8; j++) s += w[8*k + j];
            s = s >> sh;
            if (s > 65535) s = 65535;
            r[16*k +: 16] = 16'(s);
        end
        return r;
    endfunction

    function automatic logic [223:0] pack();
        logic [223:0] p = '0;
        for (int c = 0; c < 16; c++) p[14*c +: 14] = 14'(cur_s[c]);
        return p;
    endfunction

    task automatic fill(input int seed);
        for (int c = 0; c < 16; c++) cur_s[c] = (c * 1031 + seed * 977 + 211) % 16384;
    endtask

    task automatic wr(input int ch, input int p, input int g);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(ch); tbl_ped = 14'(p); tbl_gain = 8'(g);
        @(negedge clk);
        tbl_we = 1'b0;
        ped_m[ch] = p; gain_m[ch] = g;
    endtask

    // One sample through the pipe, checked at the expected cycle.
    task automatic run_one(input string req);
        logic [63:0] e;
        e = model();
        @(negedge clk);
        in_samples = pack(); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk({req, " no early valid"}, 64'(out_valid), 64'd0);
        @(negedge clk);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " sums"}, out_sums, e);
    endtask

    task automatic t_reset();
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset sums", out_sums, 64'd0);
        mode_quad = 1'b1; shift_sel = 2'd0;
        for (int c = 0; c < 16; c++) cur_s[c] = 1000 + 37 * c;
        run_one("R1 default table");
    endtask

    task automatic t_baseline();
        for (int c = 0; c < 16; c++) wr(c, 500 + 300 * c, 128);
        for (int c = 0; c < 16; c++) cur_s[c] = (c % 2 == 0) ? 4000 : 100 + c;
        run_one("R2 baseline and clamp");
    endtask

    task automatic t_gain();
        for (int c = 0; c < 16; c++) wr(c, 20 * c, (c * 53 + 7) % 256);
        wr(0, 0, 0); wr(1, 0, 255);
        fill(3);
        run_one("R3 gain weights");
    endtask

    task automatic t_quad();
        mode_quad = 1'b1; shift_sel = 2'd1;
        fill(5); run_one("R4 quad pattern a");
        fill(11); run_one("R4 quad pattern b");
    endtask

    task automatic t_pair();
        mode_quad = 1'b0; shift_sel = 2'd1;
        fill(7); run_one("R5 pair pattern a");
        for (int c = 0; c < 16; c++) cur_s[c] = (c < 8) ? 16383 : 50 * c;
        run_one("R5 pair pattern b");
        mode_quad = 1'b1;
    endtask

    task automatic t_shift();
        for (int c = 0; c < 16; c++) wr(c, 0, 255);
        for (int c = 0; c < 16; c++) cur_s[c] = 16383;
        mode_quad = 1'b1;
        for (int s = 0; s < 4; s++) begin
            shift_sel = 2'(s);
            run_one((s == 0) ? "R7 saturate quad" : "R6 shift quad");
        end
        mode_quad = 1'b0; shift_sel = 2'd2;
        run_one("R6 shift pair");
        shift_sel = 2'd1;
        run_one("R7 saturate pair");
        mode_quad = 1'b1;
    endtask

    // Back-to-back samples, one result per clock.
    task automatic t_stream();
        logic [63:0] e [6];
        shift_sel = 2'd1;
        for (int c = 0; c < 16; c++) wr(c, 10 * c, (c * 29) % 256);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (t >= 4) begin
                chk("R8 stream valid", 64'(out_valid), 64'd1);
                chk("R8 stream sums", out_sums, e[t-4]);
            end else begin
                chk("R8 stream early", 64'(out_valid), 64'd0);
            end
            if (t < 6) begin
                fill(20 + t); e[t] = model();
                in_samples = pack(); in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R8 stream end", 64'(out_valid), 64'd0);
    endtask

    // Table write on the same edge as a sample.
    task automatic t_collide();
        logic [63:0] e1, e2;
        wr(0, 100, 128);
        fill(40); cur_s[0] = 5000;
        e1 = model();
        @(negedge clk);
        in_samples = pack(); in_valid = 1'b1;
        tbl_we = 1'b1; tbl_addr = 4'd0; tbl_ped = 14'd3000; tbl_gain = 8'd128;
        ped_m[0] = 3000;
        e2 = model();
        @(negedge clk);
        tbl_we = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 same-edge sample uses old entry", out_sums, e1);
        @(negedge clk);
        chk("R9 next sample uses new entry", out_sums, e2);
    endtask

    task automatic t_hold();
        logic [63:0] last;
        last = out_sums;
        fill(60);
        in_samples = pack();
        repeat (6) @(negedge clk);
        chk("R10 no valid", 64'(out_valid), 64'd0);
        chk("R10 sums held", out_sums, last);
    endtask

    initial begin
        for (int c = 0; c < 16; c++) begin ped_m[c] = 0; gain_m[c] = 128; cur_s[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_baseline();
        t_gain();
        t_quad();
        t_pair();
        t_shift();
        t_stream();
        t_collide();
        t_hold();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_T * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule